// File: doc/BRIEF.md
# Multi-Level Indirect Address Resolver

This block turns a memory-reference instruction into a final 15-bit effective address. A caller hands it the instruction byte, the 8-bit operand and the current program counter through a valid/ready handshake. In direct mode the result is formed immediately from the operand and a base page. The base page is either page zero or the page the program counter is in. In indirect mode the operand names a location in that page. The block fetches a two-byte pointer from that location over a multiplexed bus. Each byte takes an address phase followed by a data phase.

A pointer whose top bit is set points to another pointer, so the block keeps fetching until it reads a pointer with that bit clear. A parameter caps how many pointers one instruction may fetch, so a circular chain ends with an error instead of hanging. The result appears on `ea_o` together with a one-cycle `done_o` pulse. The data access at the final address is left to the surrounding datapath.

Top module: `iar_resolver`

## Requirements
- R1: After synchronous reset, `start_ready` is 1 and `done_o`, `err_o`, `bus_ale_o` and `bus_rd_o` are 0.
- R2: An instruction with bit 1 clear and bit 0 clear is direct and page-relative. In the cycle after acceptance, `done_o` is 1, `err_o` is 0 and `ea_o` = {pc_i[14:8], operand_i}. No bus phase occurs.
- R3: An instruction with bit 1 clear and bit 0 set is direct and uses page zero. In the cycle after acceptance, `done_o` is 1 and `ea_o` = {7'b0, operand_i}.
- R4: An instruction with bit 1 set is indirect. Bus activity starts in the cycle after acceptance. The block reads the byte at the start location (the same page choice as R2/R3) as the pointer's low byte, and the byte at the next address as its high byte. If pointer bit 15 is clear, `ea_o` = pointer[14:0] with `done_o` high.
- R5: Each byte read is one cycle with `bus_ale_o` high, then one cycle with `bus_rd_o` high. During the first cycle, `bus_hi_o` = {1'b0, addr[14:8]} and `bus_lo_o` = addr[7:0]. The byte is taken from `bus_lo_i` at the end of the second cycle. A pointer fetch takes four cycles, low byte first.
- R6: A pointer with bit 15 set starts a new two-byte fetch at pointer[14:0]. Chains of any length up to the limit are followed.
- R7: At most MAX_DEPTH pointers are fetched per instruction. A chain whose MAX_DEPTH-th pointer is direct completes normally. If that pointer still has bit 15 set, `done_o` and `err_o` pulse together and `ea_o` is 0. `err_o` is never 1 without `done_o`.
- R8: `start_ready` is 0 while bus phases are in progress, and `start_valid` is ignored then. A request held during that time is accepted in the cycle of `done_o`.
- R9: The second byte address is the first plus one modulo 2^15. It crosses page boundaries and wraps from 0x7FFF to 0x0000.
- R10: Instruction bits 7 to 2 have no effect on the result or on the timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_valid | input | 1 | Request carries a new instruction |
| start_ready | output | 1 | Block can accept a request |
| instr_i | input | 8 | Instruction byte (bit 1 indirect, bit 0 page zero) |
| operand_i | input | 8 | Offset within the selected page |
| pc_i | input | 15 | Current program counter |
| bus_hi_o | output | 8 | High side of the address phase |
| bus_lo_o | output | 8 | Low side of the address phase |
| bus_lo_i | input | 8 | Read data on the low side |
| bus_ale_o | output | 1 | Address phase marker |
| bus_rd_o | output | 1 | Read data phase marker |
| ea_o | output | 15 | Resolved effective address, valid with done_o |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Chain limit exceeded, with done_o |

## Verification
A wrong sequencer state appears on the bus within one cycle as a misplaced address phase, a missing read phase or a stray ready. This happens because every cycle of a resolution has a fixed, predictable bus pattern. A low byte captured at the wrong time, or a wrong page choice, does not show until `done_o`, as a wrong `ea_o`. A wrong depth count shows only at the end of a long chain, as an early error or as one fetch too many. Chains built to end exactly at the limit and one beyond it expose that case.

// File: rtl/iar_pkg.sv
package iar_pkg;

    localparam int ADDR_W = 15;
    localparam int BYTE_W = 8;
    localparam int PAGE_W = ADDR_W - BYTE_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [2:0] {
        SEQ_IDLE   = 3'd0,
        SEQ_ADR_LO = 3'd1,
        SEQ_DAT_LO = 3'd2,
        SEQ_ADR_HI = 3'd3,
        SEQ_DAT_HI = 3'd4
    } seq_e;

    // decoded addressing fields of a memory-reference instruction
    typedef struct packed {
        logic  indirect;
        logic  zero_page;
        byte_t offset;
    } mref_t;

    // pointer fetched from memory: top bit requests another level
    typedef struct packed {
        logic  chained;
        addr_t target;
    } ptr_t;

    typedef struct packed {
        byte_t hi;
        byte_t lo;
    } bus_word_t;

    function automatic mref_t decode_mref(byte_t op, byte_t opnd);
        mref_t m;
        m.indirect  = op[1];
        m.zero_page = op[0];
        m.offset    = opnd;
        return m;
    endfunction

    function automatic addr_t page_location(mref_t m, addr_t pc);
        logic [PAGE_W-1:0] page;
        page = m.zero_page ? '0 : pc[ADDR_W-1:BYTE_W];
        return {page, m.offset};
    endfunction

    function automatic addr_t step_addr(addr_t a);
        return a + addr_t'(1);
    endfunction

    function automatic bus_word_t addr_to_bus(addr_t a);
        bus_word_t w;
        w.hi = {1'b0, a[ADDR_W-1:BYTE_W]};
        w.lo = a[BYTE_W-1:0];
        return w;
    endfunction

    function automatic ptr_t join_ptr(byte_t hi, byte_t lo);
        ptr_t p;
        p.chained = hi[BYTE_W-1];
        p.target  = {hi[BYTE_W-2:0], lo};
        return p;
    endfunction

endpackage

// File: rtl/iar_mref_decode.sv
module iar_mref_decode
    import iar_pkg::*;
(
    input  logic [7:0]        instr_i,
    input  logic [7:0]        operand_i,
    input  logic [ADDR_W-1:0] pc_i,
    output mref_t             mref_o,
    output addr_t             loc_o
);
    // opcode field and low pc bits do not take part in addressing
    logic unused_fields;
    assign unused_fields = ^{instr_i[7:2], pc_i[BYTE_W-1:0]};

    always_comb begin
        mref_o = decode_mref(instr_i, operand_i);
        loc_o  = page_location(mref_o, pc_i);
    end
endmodule

// File: rtl/iar_ptr_gather.sv
module iar_ptr_gather
    import iar_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  take_lo,
    input  byte_t byte_i,
    output ptr_t  ptr_o
);
    byte_t lo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= '0;
        end else if (take_lo) begin
            lo_q <= byte_i;
        end
    end

    // high byte is consumed in the same cycle it arrives
    assign ptr_o = join_ptr(byte_i, lo_q);
endmodule

// File: rtl/iar_depth_guard.sv
module iar_depth_guard #(
    parameter int MAX_DEPTH = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic advance,
    output logic last_level
);
    localparam int CNT_W = (MAX_DEPTH > 1) ? $clog2(MAX_DEPTH) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(MAX_DEPTH - 1);

    logic [CNT_W-1:0] fetched_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            fetched_q <= '0;
        end else if (advance) begin
            fetched_q <= fetched_q + 1'b1;
        end
    end

    // the fetch now finishing is number fetched_q + 1
    assign last_level = (fetched_q == LAST_IDX);
endmodule

// File: rtl/iar_bus_drive.sv
module iar_bus_drive
    import iar_pkg::*;
(
    input  seq_e  state_i,
    input  addr_t base_i,
    output logic  ale_o,
    output logic  rd_o,
    output byte_t hi_o,
    output byte_t lo_o
);
    bus_word_t word;
    addr_t     target;

    always_comb begin
        ale_o  = (state_i == SEQ_ADR_LO) || (state_i == SEQ_ADR_HI);
        rd_o   = (state_i == SEQ_DAT_LO) || (state_i == SEQ_DAT_HI);
        target = (state_i == SEQ_ADR_HI) ? step_addr(base_i) : base_i;
        word   = ale_o ? addr_to_bus(target) : '0;
        hi_o   = word.hi;
        lo_o   = word.lo;
    end
endmodule

// File: rtl/iar_resolver.sv
module iar_resolver
    import iar_pkg::*;
#(
    parameter int MAX_DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_valid,
    output logic        start_ready,
    input  logic [7:0]  instr_i,
    input  logic [7:0]  operand_i,
    input  logic [14:0] pc_i,
    output logic [7:0]  bus_hi_o,
    output logic [7:0]  bus_lo_o,
    input  logic [7:0]  bus_lo_i,
    output logic        bus_ale_o,
    output logic        bus_rd_o,
    output logic [14:0] ea_o,
    output logic        done_o,
    output logic        err_o
);
    seq_e  state_q;
    addr_t cur_q;
    addr_t ea_q;
    logic  done_q;
    logic  err_q;

    mref_t mref;
    addr_t start_loc;
    ptr_t  ptr_now;
    logic  last_level;
    logic  accept;
    logic  chain_on;

    iar_mref_decode u_decode (
        .instr_i   (instr_i),
        .operand_i (operand_i),
        .pc_i      (pc_i),
        .mref_o    (mref),
        .loc_o     (start_loc)
    );

    iar_ptr_gather u_gather (
        .clk     (clk),
        .rst     (rst),
        .take_lo (state_q == SEQ_DAT_LO),
        .byte_i  (bus_lo_i),
        .ptr_o   (ptr_now)
    );

    iar_depth_guard #(.MAX_DEPTH(MAX_DEPTH)) u_guard (
        .clk        (clk),
        .rst        (rst),
        .clear      (accept),
        .advance    (chain_on),
        .last_level (last_level)
    );

    iar_bus_drive u_bus (
        .state_i (state_q),
        .base_i  (cur_q),
        .ale_o   (bus_ale_o),
        .rd_o    (bus_rd_o),
        .hi_o    (bus_hi_o),
        .lo_o    (bus_lo_o)
    );

    assign start_ready = (state_q == SEQ_IDLE);
    assign accept      = start_valid && start_ready;
    assign chain_on    = (state_q == SEQ_DAT_HI) && ptr_now.chained && !last_level;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            cur_q   <= '0;
            ea_q    <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            unique case (state_q)
                SEQ_IDLE: begin
                    if (accept) begin
                        if (mref.indirect) begin
                            cur_q   <= start_loc;
                            state_q <= SEQ_ADR_LO;
                        end else begin
                            ea_q   <= start_loc;
                            done_q <= 1'b1;
                        end
                    end
                end
                SEQ_ADR_LO: state_q <= SEQ_DAT_LO;
                SEQ_DAT_LO: state_q <= SEQ_ADR_HI;
                SEQ_ADR_HI: state_q <= SEQ_DAT_HI;
                SEQ_DAT_HI: begin
                    if (!ptr_now.chained) begin
                        ea_q    <= ptr_now.target;
                        done_q  <= 1'b1;
                        state_q <= SEQ_IDLE;
                    end else if (last_level) begin
                        ea_q    <= '0;
                        err_q   <= 1'b1;
                        done_q  <= 1'b1;
                        state_q <= SEQ_IDLE;
                    end else begin
                        cur_q   <= ptr_now.target;
                        state_q <= SEQ_ADR_LO;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign ea_o   = ea_q;
    assign done_o = done_q;
    assign err_o  = err_q;
endmodule

// File: rtl/iar_resolver_chk.sv
module iar_resolver_chk (
    input logic        clk,
    input logic        rst,
    input logic        start_valid,
    input logic        start_ready,
    input logic [7:0]  instr_i,
    input logic [7:0]  operand_i,
    input logic [14:0] pc_i,
    input logic        bus_ale_o,
    input logic        bus_rd_o,
    input logic [14:0] ea_o,
    input logic        done_o,
    input logic        err_o
);
    logic take_direct;
    logic take_indirect;
    assign take_direct   = start_valid && start_ready && !instr_i[1];
    assign take_indirect = start_valid && start_ready && instr_i[1];

    AST_DIRECT_DONE: assert property (@(posedge clk) disable iff (rst)
        take_direct |=> done_o && !err_o && !bus_ale_o && !bus_rd_o); // R2
    AST_DIRECT_PAGE: assert property (@(posedge clk) disable iff (rst)
        take_direct && !instr_i[0] |=> ea_o == {$past(pc_i[14:8]), $past(operand_i)}); // R2
    AST_DIRECT_ZERO: assert property (@(posedge clk) disable iff (rst)
        take_direct && instr_i[0] |=> ea_o == {7'b0, $past(operand_i)}); // R3
    AST_INDIRECT_START: assert property (@(posedge clk) disable iff (rst)
        take_indirect |=> bus_ale_o && !done_o); // R4
    AST_ALE_THEN_RD: assert property (@(posedge clk) disable iff (rst)
        bus_ale_o |=> bus_rd_o && !bus_ale_o); // R5
    AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(bus_ale_o && bus_rd_o)); // R5
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        err_o |-> done_o); // R7
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        (bus_ale_o || bus_rd_o) |-> !start_ready && !done_o); // R8
endmodule

bind iar_resolver iar_resolver_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .start_valid (start_valid),
    .start_ready (start_ready),
    .instr_i     (instr_i),
    .operand_i   (operand_i),
    .pc_i        (pc_i),
    .bus_ale_o   (bus_ale_o),
    .bus_rd_o    (bus_rd_o),
    .ea_o        (ea_o),
    .done_o      (done_o),
    .err_o       (err_o)
);

// File: tb/iar_resolver_tb.sv
`timescale 1ns/1ps
module iar_resolver_tb;
    localparam int DEPTH = 4;
    localparam int WATCHDOG = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_valid = 1'b0;
    logic        start_ready;
    logic [7:0]  instr_i = '0;
    logic [7:0]  operand_i = '0;
    logic [14:0] pc_i = '0;
    logic [7:0]  bus_hi_o, bus_lo_o;
    logic [7:0]  bus_lo_i = '0;
    logic        bus_ale_o, bus_rd_o;
    logic [14:0] ea_o;
    logic        done_o, err_o;

    always #2 clk = ~clk;

    iar_resolver #(.MAX_DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .start_valid(start_valid), .start_ready(start_ready),
        .instr_i(instr_i), .operand_i(operand_i), .pc_i(pc_i),
        .bus_hi_o(bus_hi_o), .bus_lo_o(bus_lo_o), .bus_lo_i(bus_lo_i),
        .bus_ale_o(bus_ale_o), .bus_rd_o(bus_rd_o),
        .ea_o(ea_o), .done_o(done_o), .err_o(err_o)
    );

    typedef struct {
        bit    ale;
        bit    rd;
        bit    rdy;
        bit    done;
        bit    err;
        int    addr;
        int    ea;
        string tag;
    } exp_t;

    exp_t           exp_q[$];
    logic [7:0]     mem[int];
    string          cur_tag = "R1";
    int             checks = 0;
    int             fails = 0;
    int             cycles = 0;

    function automatic logic [7:0] mrd(int a);
        return mem.exists(a) ? mem[a] : 8'h00;
    endfunction

    function automatic exp_t blank(string t);
        exp_t e;
        e.ale = 0; e.rd = 0; e.rdy = 1; e.done = 0; e.err = 0;
        e.addr = 0; e.ea = 0; e.tag = t;
        return e;
    endfunction

    // behavioural prediction of every cycle following an acceptance
    task automatic predict(logic [7:0] op, logic [7:0] opnd, logic [14:0] pc);
        exp_t e;
        int   loc;
        int   lvl;
        logic [7:0] lo, hi;
        loc = op[0] ? int'(opnd) : ((int'(pc) & 32'h7F00) | int'(opnd));
        if (!op[1]) begin
            e = blank(cur_tag); e.done = 1; e.ea = loc;
            exp_q.push_back(e);
            return;
        end
        lvl = 0;
        forever begin
            e = blank("R5"); e.rdy = 0; e.ale = 1; e.addr = loc; exp_q.push_back(e);
            e = blank("R5"); e.rdy = 0; e.rd = 1; exp_q.push_back(e);
            e = blank("R5"); e.rdy = 0; e.ale = 1; e.addr = (loc + 1) & 32'h7FFF; exp_q.push_back(e);
            e = blank("R5"); e.rdy = 0; e.rd = 1; exp_q.push_back(e);
            lo = mrd(loc);
            hi = mrd((loc + 1) & 32'h7FFF);
            lvl++;
            if (!hi[7]) begin
                e = blank(cur_tag); e.done = 1; e.ea = int'({hi[6:0], lo});
                exp_q.push_back(e);
                return;
            end
            if (lvl == DEPTH) begin
                e = blank(cur_tag); e.done = 1; e.err = 1; e.ea = 0;
                exp_q.push_back(e);
                return;
            end
            loc = int'({hi[6:0], lo});
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (rst) exp_q.delete();
        else if (start_valid && exp_q.size() == 0) predict(instr_i, operand_i, pc_i);
    end

    always @(negedge clk) begin
        exp_t e;
        bit   bad;
        if (!rst) begin
            e = (exp_q.size() > 0) ? exp_q.pop_front() : blank("R1");
            bad = 0;
            checks++;
            if (bus_ale_o !== e.ale || bus_rd_o !== e.rd) begin
                $display("FAIL R5 phases actual ale=%0b rd=%0b expected ale=%0b rd=%0b (%s)",
                         bus_ale_o, bus_rd_o, e.ale, e.rd, e.tag);
                bad = 1;
            end
            if (e.ale && int'({bus_hi_o, bus_lo_o}) != e.addr) begin
                $display("FAIL %s address actual=%h expected=%h",
                         (e.addr[14:0] == 15'h0000) ? "R9" : "R5", {bus_hi_o, bus_lo_o}, e.addr[15:0]);
                bad = 1;
            end
            if (start_ready !== e.rdy) begin
                $display("FAIL R8 ready actual=%0b expected=%0b", start_ready, e.rdy);
                bad = 1;
            end
            if (done_o !== e.done || err_o !== e.err) begin
                $display("FAIL %s done/err actual=%0b/%0b expected=%0b/%0b",
                         e.tag, done_o, err_o, e.done, e.err);
                bad = 1;
            end
            if (e.done && int'(ea_o) != e.ea) begin
                $display("FAIL %s ea actual=%h expected=%h", e.tag, ea_o, e.ea[14:0]);
                bad = 1;
            end
            if (bad) fails++;
            if (bus_ale_o) bus_lo_i = mrd(int'({bus_hi_o[6:0], bus_lo_o}));
        end
    end

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cycles > WATCHDOG) begin
            fails++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            finish_run();
        end
    end

    task automatic wait_idle();
        do begin
            @(posedge clk);
            #1;
        end while (exp_q.size() > 1);
    endtask

    task automatic issue(logic [7:0] op, logic [7:0] opnd, logic [14:0] pc, string tag);
        wait_idle();
        @(negedge clk);
        instr_i = op; operand_i = opnd; pc_i = pc; cur_tag = tag;
        start_valid = 1'b1;
        @(negedge clk);
        start_valid = 1'b0;
    endtask

    initial begin
        // pointer tables (low byte first)
        mem[32'h0010] = 8'h78; mem[32'h0011] = 8'h25;            // R4 page zero
        mem[32'h3340] = 8'hCD; mem[32'h3341] = 8'h12;            // R4 pc page
        mem[32'h0020] = 8'h00; mem[32'h0021] = 8'h85;            // R6 chain
        mem[32'h0500] = 8'h10; mem[32'h0501] = 8'h86;
        mem[32'h0610] = 8'hEF; mem[32'h0611] = 8'h3B;
        mem[32'h0030] = 8'h30; mem[32'h0031] = 8'h80;            // R7 self loop
        mem[32'h0040] = 8'h00; mem[32'h0041] = 8'h81;            // R7 exactly at limit
        mem[32'h0100] = 8'h00; mem[32'h0101] = 8'h82;
        mem[32'h0200] = 8'h00; mem[32'h0201] = 8'h83;
        mem[32'h0300] = 8'h55; mem[32'h0301] = 8'h44;
        mem[32'h7FFF] = 8'h22; mem[32'h0000] = 8'h11;            // R9 wrap
        mem[32'h12FF] = 8'h9A; mem[32'h1300] = 8'h07;            // R9 page cross

        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);                                // R1 idle after reset

        issue(8'b1011_0000, 8'h34, 15'h1A55, "R2");               // direct, pc page
        issue(8'b1011_0001, 8'h9C, 15'h1A55, "R3");               // direct, page zero
        issue(8'b0100_1011, 8'h10, 15'h6000, "R4");               // indirect, page zero
        issue(8'b0100_1010, 8'h40, 15'h3300, "R4");               // indirect, pc page
        issue(8'b0000_0011, 8'h20, 15'h0000, "R6");               // three-level chain
        issue(8'b0000_0011, 8'h30, 15'h0000, "R7");               // loop hits the limit
        issue(8'b0000_0011, 8'h40, 15'h0000, "R7");               // limit reached, direct
        issue(8'b0000_0010, 8'hFF, 15'h7F00, "R9");               // second byte wraps
        issue(8'b0000_0010, 8'hFF, 15'h1280, "R9");               // second byte crosses page
        issue(8'hFC, 8'h5A, 15'h2B11, "R10");                     // upper opcode bits set
        issue(8'h00, 8'h5A, 15'h2B11, "R10");                     // upper opcode bits clear
        issue(8'hFF, 8'h10, 15'h0000, "R10");                     // indirect with bits set

        // R8: hold a request while a resolution is in flight
        issue(8'b0000_0011, 8'h10, 15'h0000, "R8");
        instr_i = 8'b0000_0001; operand_i = 8'hA5; pc_i = 15'h0000;
        start_valid = 1'b1;
        repeat (8) @(negedge clk);
        start_valid = 1'b0;

        // back-to-back direct requests
        issue(8'b0000_0000, 8'h01, 15'h4400, "R2");
        issue(8'b0000_0001, 8'hFE, 15'h4400, "R3");

        wait_idle();
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule